// File: doc/BRIEF.md
# Drop-on-Busy Stream FIFO Port

This block is a single-clock FIFO. Its write side and its read side are both point-to-point valid/ready streams. The write side behaves as a sink that never stalls its producer. The sink shows `in_ready` only when it is out of reset and has free space. A word offered while `in_ready` is low is thrown away, so the producer never has to hold a word or retry it. The producer may keep `in_valid` high for back-to-back writes.

The read side pushes words out only while the consumer holds `out_ready` high. `out_valid` is registered. A word pops in any cycle where `out_ready` is high and the FIFO holds data, and it appears with `out_valid` in the next cycle. When `out_ready` falls, the read side therefore stops one cycle later, and at most one final word follows the fall.

The block exposes its stored word count. It also drives two threshold flags that feed interrupt logic:
- `prog_full` rises when the count is strictly above a programmed value. This suits a receive buffer.
- `prog_empty` rises when the count is strictly below a second programmed value. This suits a transmit buffer.

The count and the thresholds are `$clog2(DEPTH)+1` bits wide. For depths of 256, 512 and 1024 that gives 9, 10 and 11 bits.

Top module: `drop_stream_fifo`

## Requirements
- R1: While `rst` is high, `in_ready` is low. After any clock edge with `rst` high, `level` is 0, `out_valid` is 0 and all stored words are gone.
- R2: Out of reset, `in_ready` is high exactly when `level` is below DEPTH.
- R3: At an edge where `in_valid` and `in_ready` are both high, `in_data` is stored, and `level` then rises by one unless a word pops at the same edge.
- R4: At an edge where `in_valid` is high and `in_ready` is low, the word is discarded. It never appears on `out_data`, and `level` does not change through it.
- R5: `out_valid` is high in the cycle after an edge at which `out_ready` was high and `level` was non-zero, and low otherwise. Words leave in the order they were accepted, and each appears on `out_data` while `out_valid` is high.
- R6: After an edge where `out_ready` is low, `out_valid` is low for the following cycle, and no word is removed at that edge.
- R7: `prog_full` is 1 exactly when `level > thr_full`, compared as unsigned values.
- R8: `prog_empty` is 1 exactly when `level < thr_empty`, compared as unsigned values.
- R9: `level` equals the number of words accepted and not yet popped, and is `$clog2(DEPTH)+1` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also blocks writes |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | DW | Offered word |
| in_ready | output | 1 | Sink open: not in reset and not full |
| out_ready | input | 1 | Consumer accepts words |
| out_valid | output | 1 | Registered: `out_data` carries a word this cycle |
| out_data | output | DW | Popped word |
| thr_full | input | $clog2(DEPTH)+1 | Upper threshold for `prog_full` |
| thr_empty | input | $clog2(DEPTH)+1 | Lower threshold for `prog_empty` |
| prog_full | output | 1 | `level` strictly above `thr_full` |
| prog_empty | output | 1 | `level` strictly below `thr_empty` |
| level | output | $clog2(DEPTH)+1 | Stored word count |

## Verification
The embedded assertions check the following in every cycle:
- reset clears the count and `out_valid`;
- a low `out_ready` silences the next cycle;
- `out_valid` only follows a non-empty FIFO;
- an accepted word raises the count by one;
- an offer refused while full leaves the count unchanged.

Only the bench's scenarios can show the rest:
- word ordering;
- that words dropped while full never reappear;
- the single trailing word after `out_ready` falls;
- both threshold comparisons at every level against every threshold, including the equal case.

// File: rtl/drop_stream_fifo.sv
module drop_stream_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic [CW-1:0] thr_full,
  input  logic [CW-1:0] thr_empty,
  output logic          prog_full,
  output logic          prog_empty,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign in_ready   = !rst && (level != FULL_N);
  assign push       = in_valid && in_ready;
  assign pop        = out_ready && (level != '0);
  assign prog_full  = level > thr_full;
  assign prog_empty = level < thr_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      level     <= level + CW'(push) - CW'(pop);
      out_valid <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
    if (!rst && pop) out_data <= mem[rd_ptr];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (level == '0 && !out_valid));

  // R6
  ready_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> !out_valid);

  // R5
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready && level == '0 |=> !out_valid);

  // R3
  accept_count_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !out_ready |=> level == $past(level) + 1'b1);

  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready && !out_ready |=> $stable(level));

endmodule

// File: tb/drop_stream_fifo_bench.sv
module drop_stream_fifo_bench;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] thr_full = '0, thr_empty = '0;
  logic in_ready, out_valid, prog_full, prog_empty;
  logic [DW-1:0] out_data;
  logic [CW-1:0] level;

  always #5 clk = ~clk;

  drop_stream_fifo #(.DW(DW), .DEPTH(DEPTH)) u_drop_stream_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .thr_full(thr_full), .thr_empty(thr_empty),
    .prog_full(prog_full), .prog_empty(prog_empty), .level(level));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_d;
  bit exp_v;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input logic [DW-1:0] id, input bit ordy, input bit r);
    bit push, pop, drop;
    rst = r; in_valid = iv; in_data = id; out_ready = ordy;
    #1;
    chk(r ? "R1 in_ready" : "R2 in_ready", int'(in_ready),
        int'(!r && q.size() < DEPTH));
    @(posedge clk);
    push = 0; pop = 0; drop = 0;
    if (r) begin
      q.delete();
      exp_v = 0;
    end else begin
      push = iv && q.size() < DEPTH;
      drop = iv && !push;
      pop  = ordy && q.size() > 0;
      if (pop) exp_d = q.pop_front();
      if (push) q.push_back(id);
      exp_v = pop;
    end
    @(negedge clk);
    chk(r ? "R1 out_valid" : (ordy ? "R5 out_valid" : "R6 out_valid"),
        int'(out_valid), int'(exp_v));
    if (exp_v) chk("R5 out_data", int'(out_data), int'(exp_d));
    chk(r ? "R1 level" : (drop ? "R4 level" : (push ? "R3 level" : "R9 level")),
        int'(level), q.size());
    chk("R7 prog_full", int'(prog_full), int'(q.size() > int'(thr_full)));
    chk("R8 prog_empty", int'(prog_empty), int'(q.size() < int'(thr_empty)));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), 1, 1);
    thr_full = 4'd5; thr_empty = 4'd3;
    for (int i = 0; i < 12; i++) step(1, 8'(i + 1), 0, 0);
    for (int i = 0; i < 10; i++) step(0, 8'h00, 1, 0);
    for (int i = 0; i < 8; i++) step(1, 8'h40 + 8'(i), 0, 0);
    for (int i = 0; i < 12; i++) step(0, 8'h00, (i % 3) != 2, 0);
    for (int i = 0; i < 30; i++) step((i % 2) == 0, 8'h80 + 8'(i), (i % 4) != 0, 0);
    for (int i = 0; i < 5; i++) step(1, 8'hC0 + 8'(i), 0, 0);
    step(1, 8'hEE, 0, 1);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 1, 0);
    for (int t = 0; t <= DEPTH; t++) begin
      thr_full = CW'(t); thr_empty = CW'(DEPTH - t);
      for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(t * 16 + i), 0, 0);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 1, 0);
    end
    for (int i = 0; i < 200; i++)
      step((i % 5) != 1, 8'(i * 7), ((i / 3) % 2) == 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule